// File: doc/BRIEF.md
# NRZI Transmit Serializer

The block takes a stream of 5-bit line symbols and sends them out one bit per clock. The serial non-return-to-zero (NRZ) stream is turned into NRZI and driven on a true and complement output pair. One bit clock drives all the logic. A modulo-5 counter inside the block marks the symbol slots, so the symbol rate is exactly one fifth of the bit rate.

A symbol is offered on a valid/ready interface. Ready is high for one cycle in each five-cycle slot. Valid and data presented in any other cycle are ignored. A producer that has a symbol keeps valid and data steady until it sees ready. If valid is low in the ready cycle, the block does not stall. It sends an all-zero idle symbol for that slot, which holds the line level. The captured symbol moves into a shift register at the next slot boundary and is sent most significant bit first. The plain NRZ bit is also brought out for loopback.

A force input parks the pair at logical zero, with the true output low and the complement output high. The NRZI level register is cleared while force is high, so the first bit after release starts from a known level. Shifting carries on under force, so symbol timing is never lost.

Top module: `nrzi_tx_serializer`

## Requirements
- R1: While reset is high, tx_p is 0, tx_n is 1, nrz_loop is 0 and sym_ready is 1.
- R2: After reset, sym_ready is high in the first cycle and then exactly once every 5 cycles.
- R3: If sym_valid is low in a ready cycle, the all-zero idle symbol is captured for that slot, and the line level does not change for its five bits.
- R4: A symbol accepted in a ready cycle (sym_valid and sym_ready both high) appears on nrz_loop over the 5 cycles that begin 5 cycles after the ready cycle. The next symbol's bits follow with no gap.
- R5: Within a symbol, sym_data[4] is sent first and sym_data[0] is sent last.
- R6: When force_zero was low in the previous cycle, tx_p equals its previous value XOR the previous nrz_loop bit. A 1 toggles the line and a 0 holds it.
- R7: tx_n is always the inverse of tx_p.
- R8: In the cycle after force_zero is high, tx_p is 0 and tx_n is 1. After release, NRZI encoding resumes from level 0. nrz_loop keeps advancing while force is high.
- R9: sym_valid and sym_data in cycles where sym_ready is low have no effect on nrz_loop, tx_p or tx_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 5 | Symbol, bit 4 sent first |
| sym_ready | output | 1 | Symbol accepted this cycle (one cycle per slot) |
| force_zero | input | 1 | Park the output pair at logical 0 |
| tx_p | output | 1 | NRZI line, true |
| tx_n | output | 1 | NRZI line, complement |
| nrz_loop | output | 1 | Serial NRZ bit for loopback |

## Verification
The hardest case to reach is a force pulse that starts in one slot and ends in another while bits of a symbol are still shifting. In that case the resumed NRZI level depends only on bits sent after release. The stimulus sets force with a per-cycle mask inside slot-aligned tasks. This lets force straddle a slot boundary, and it is combined with non-zero symbols. Ignored inputs are driven with random valid and data values in every non-ready cycle, and the serial and line outputs are compared cycle by cycle with a queue-based model.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } bit_order_e;

  // next NRZI level: park at 0 under force, otherwise a 1 toggles
  function automatic logic nrzi_next(logic level, logic nrz_bit, logic park);
    return park ? 1'b0 : (level ^ nrz_bit);
  endfunction

endpackage

// File: rtl/nrzi_sym_timer.sv
module nrzi_sym_timer #(
  parameter int SYM_W = 5
) (
  input  logic clk,
  input  logic rst,
  output logic slot_first,
  output logic slot_last
);
  localparam int CW = (SYM_W > 2) ? $clog2(SYM_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign slot_first = (cnt == '0);
  assign slot_last  = (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < (CW+1)'(SYM_W)));

  // R2
  single_ready_chk: assert property (@(posedge clk) disable iff (rst)
    slot_first |=> !slot_first);

endmodule

// File: rtl/nrzi_sym_capture.sv
module nrzi_sym_capture #(
  parameter int               SYM_W = 5,
  parameter logic [SYM_W-1:0] IDLE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_first,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic [SYM_W-1:0] held
);
  logic armed;

  assign in_ready = slot_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= IDLE;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (slot_first) held <= in_valid ? in_data : IDLE;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(slot_first)) |-> $stable(held));

  // R3
  idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(slot_first) && !$past(in_valid)) |-> (held == IDLE));

endmodule

// File: rtl/nrzi_shifter.sv
module nrzi_shifter
  import nrzi_tx_pkg::*;
#(
  parameter int         SYM_W = 5,
  parameter bit_order_e ORDER = ORDER_MSB_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] load_data,
  output logic             nrz
);
  localparam int TOP = SYM_W - 1;

  logic [SYM_W-1:0] sh;
  logic             lead;
  logic             armed;

  generate
    if (ORDER == ORDER_MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= load_data;
        else           sh <= {sh[TOP-1:0], 1'b0};
      end
      assign nrz  = sh[TOP];
      assign lead = load_data[TOP];
    end else begin : g_lsb
      always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= load_data;
        else           sh <= {1'b0, sh[TOP:1]};
      end
      assign nrz  = sh[0];
      assign lead = load_data[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R5
  lead_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(load)) |-> (nrz == $past(lead)));

endmodule

// File: rtl/nrzi_line_encoder.sv
module nrzi_line_encoder
  import nrzi_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nrz,
  input  logic park,
  output logic tx_p,
  output logic tx_n
);
  logic lvl_next;
  logic armed;

  assign lvl_next = nrzi_next(tx_p, nrz, park);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_p  <= 1'b0;
      tx_n  <= 1'b1;
      armed <= 1'b0;
    end else begin
      tx_p  <= lvl_next;
      tx_n  <= ~lvl_next;
      armed <= 1'b1;
    end
  end

  // R8
  park_low_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(park)) |-> (!tx_p && tx_n));

  // R6
  toggle_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(park)) |-> (tx_p == ($past(tx_p) ^ $past(nrz))));

  // R7
  pair_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_n == !tx_p);

endmodule

// File: rtl/nrzi_tx_serializer.sv
module nrzi_tx_serializer
  import nrzi_tx_pkg::*;
#(
  parameter int               SYM_W       = 5,
  parameter logic [SYM_W-1:0] IDLE_SYMBOL = '0,
  parameter bit_order_e       ORDER       = ORDER_MSB_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  output logic             sym_ready,
  input  logic             force_zero,
  output logic             tx_p,
  output logic             tx_n,
  output logic             nrz_loop
);
  logic             slot_first;
  logic             slot_last;
  logic [SYM_W-1:0] held;

  nrzi_sym_timer #(.SYM_W(SYM_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .slot_first (slot_first),
    .slot_last  (slot_last)
  );

  nrzi_sym_capture #(.SYM_W(SYM_W), .IDLE(IDLE_SYMBOL)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .slot_first (slot_first),
    .in_valid   (sym_valid),
    .in_data    (sym_data),
    .in_ready   (sym_ready),
    .held       (held)
  );

  nrzi_shifter #(.SYM_W(SYM_W), .ORDER(ORDER)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .load      (slot_last),
    .load_data (held),
    .nrz       (nrz_loop)
  );

  nrzi_line_encoder u_line (
    .clk  (clk),
    .rst  (rst),
    .nrz  (nrz_loop),
    .park (force_zero),
    .tx_p (tx_p),
    .tx_n (tx_n)
  );

endmodule

// File: tb/nrzi_tx_serializer_test.sv
module nrzi_tx_serializer_test;
  localparam int W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic         sym_valid = 1'b0;
  logic [W-1:0] sym_data = '0;
  logic         force_zero = 1'b0;
  logic         sym_ready, tx_p, tx_n, nrz_loop;

  nrzi_tx_serializer uut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .force_zero(force_zero),
    .tx_p(tx_p), .tx_n(tx_n), .nrz_loop(nrz_loop)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string tag = "R4";

  // behavioural reference: slot phase, accepted symbol, pending bit queue, line level
  int m_cnt = 0;
  int m_hold = 0;
  bit m_line = 0;
  bit m_fprev = 0;
  int q[$];

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_hold = 0; m_line = 0; m_fprev = 0;
      q.delete();
    end else begin
      bit b;
      b = (q.size() > 0) ? (q[0] != 0) : 1'b0;
      if (q.size() > 0) void'(q.pop_front());
      m_line  = force_zero ? 1'b0 : (m_line ^ b);
      m_fprev = force_zero;
      if (m_cnt == W-1)
        for (int i = W-1; i >= 0; i--) q.push_back((m_hold >> i) & 1);
      if (m_cnt == 0) m_hold = sym_valid ? int'(sym_data) : 0;
      m_cnt = (m_cnt + 1) % W;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2", sym_ready, m_cnt == 0);
      check(tag, nrz_loop, (q.size() > 0) && (q[0] != 0));
      check(m_fprev ? "R8" : "R6", tx_p, m_line);
      check("R7", tx_n, ~m_line);
    end
  end

  // one five-cycle slot; fmask gives force per cycle, noise scrambles non-ready cycles (R9)
  task automatic slot(bit v, logic [W-1:0] d, bit noise, logic [W-1:0] fmask);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      force_zero = fmask[i];
      if (m_cnt == 0) begin
        sym_valid = v; sym_data = d;
      end else if (noise) begin
        sym_valid = 1'($urandom); sym_data = W'($urandom);
      end else begin
        sym_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tx_p, 1'b0);
    check("R1", tx_n, 1'b1);
    check("R1", nrz_loop, 1'b0);
    check("R1", sym_ready, 1'b1);
    rst = 1'b0;

    tag = "R5";
    slot(1, 5'b10000, 0, '0);
    slot(1, 5'b00001, 0, '0);
    slot(1, 5'b11111, 0, '0);
    slot(1, 5'b10110, 0, '0);

    tag = "R4";
    for (int k = 0; k < 20; k++) slot(1, W'($urandom), 0, '0);

    tag = "R9";
    for (int k = 0; k < 20; k++) slot(1, W'($urandom), 1, '0);

    tag = "R3";
    slot(1, 5'b11111, 1, '0);
    for (int k = 0; k < 4; k++) slot(0, 5'b11111, 1, '0);

    tag = "R8";
    slot(1, 5'b11111, 0, 5'b11100);
    slot(1, 5'b10101, 0, 5'b00011);
    slot(1, 5'b11011, 0, 5'b11111);
    slot(1, 5'b01110, 0, 5'b00100);
    for (int k = 0; k < 10; k++) slot(1, W'($urandom), 1, W'($urandom));

    tag = "R4";
    for (int k = 0; k < 3; k++) slot(0, '0, 0, '0);

    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule